// File: doc/BRIEF.md
# Byte-Lane Static Memory Control Decoder

This block is a clocked, synthesizable model of a 16-bit-wide static memory together with its control decoding. It receives two chip selects of opposite polarity, an active-low write enable, an active-low output enable and one active-low select per byte lane. From these it decides, once per cycle, whether the memory is idle, has its outputs disabled, is reading or is writing. For each byte lane it produces a drive enable for the read path and a write strobe for the store.

A write takes place only while every enabling condition overlaps. Any one of them can open the window by being the last to become active, and any one can close it by being the first to drop. A byte lane whose select is inactive keeps its stored byte. Read data is registered. A lane's drive enable rises one cycle after the read condition is first seen, and falls in the same cycle that the condition or the lane's select goes away.

The address port is 18 bits wide. The storage array is sized by its own parameter, so the default build stays small. Only the low address bits select a word.

The control is a four-state machine over an enumerated mode, advanced by the mode decoded from the pins on each clock edge:
- `ST_IDLE`: standby.
- `ST_HOLD`: outputs disabled.
- `ST_READ`: reading.
- `ST_WRITE`: writing.

Every state can move to any state. The transitions are:
- enter-standby: the chip is deselected or no byte is selected.
- enter-hold: the chip is selected, at least one byte is selected, and both write and output enables are inactive.
- enter-read: the chip is selected, at least one byte is selected, write enable is inactive and output enable is active.
- enter-write: the chip is selected, at least one byte is selected and write enable is active.

Top module: `lane_sram_ctl`

## Requirements
- R1: Standby applies when `cs_n`=1, or `cs_hi`=0, or `byte_sel_n`=2'b11. In standby, `lane_oe` and `lane_wstb` are both 2'b00 and no stored byte changes.
- R2: While `rst_n` is low, and in the first cycle after it, `lane_oe` is 2'b00 and `dout` is 0.
- R3: A read needs `cs_n`=0, `cs_hi`=1, `we_n`=1 and `oe_n`=0. When the read holds at a clock edge and still holds afterwards, `lane_oe[i]` is 1 for each lane selected (`byte_sel_n[i]`=0) both at that edge and now. That lane of `dout` then shows the byte stored at the address sampled on that edge. Lane 0 is `dout[7:0]` and lane 1 is `dout[15:8]`.
- R4: `lane_oe[i]` falls in the same cycle that the read condition, or the select of lane `i`, becomes inactive.
- R5: A write needs `cs_n`=0, `cs_hi`=1 and `we_n`=0, whatever the value of `oe_n`. `lane_wstb[i]` is 1 in that same cycle for each lane with `byte_sel_n[i]`=0. At the clock edge, that lane's byte of `din` is stored at the addressed word.
- R6: During a write, the byte of a lane whose select is 1 keeps its previous stored value.
- R7: With `cs_n`=0, `cs_hi`=1, `we_n`=1 and `oe_n`=1 (output disable), `lane_oe` and `lane_wstb` are 2'b00.
- R8: No cycle has any bit of `lane_oe` and any bit of `lane_wstb` set at the same time.
- R9: Only `addr[STORE_AW-1:0]` selects a word (default 10 bits, 1024 words). Higher address bits have no effect.
- R10: Each lane of `dout` reads 0 whenever that lane's `lane_oe` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_sel_n | input | 2 | Byte lane selects, active low; bit 0 is the low byte |
| addr | input | 18 | Word address |
| din | input | 16 | Write data side of the shared data bus |
| dout | output | 16 | Read data side of the shared data bus, zero on undriven lanes |
| lane_oe | output | 2 | Per-lane drive enable for the read path |
| lane_wstb | output | 2 | Per-lane write strobe |

## Verification
Write strobes are combinational, so the bench checks them in the cycle the stimulus is applied. A stored byte becomes visible only through a read that starts at a later edge, and read data and drive enables arrive exactly one edge after the read is first decoded. The drop of a drive enable, by contrast, is due in the stimulus cycle itself.

The bench applies inputs just after the falling edge and compares all outputs 1 ns later against a behavioural model. It advances that model at the rising edge, so every check sees only registers that have been updated by the edges that have actually passed.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } sram_mode_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/lane_sram_decode.sv
module lane_sram_decode
    import lane_sram_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic             cs_n,
    input  logic             cs_hi,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] byte_sel_n,
    output sram_mode_e       mode_now,
    output logic [LANES-1:0] lane_req
);

    logic chip_on;
    logic any_lane;

    assign chip_on  = !cs_n && cs_hi;
    assign any_lane = |(~byte_sel_n);
    assign lane_req = chip_on ? ~byte_sel_n : '0;

    // Priority: deselect first, then write, then read, else outputs held off
    always_comb begin
        if (!(chip_on && any_lane)) begin
            mode_now = ST_IDLE;
        end else if (!we_n) begin
            mode_now = ST_WRITE;
        end else if (!oe_n) begin
            mode_now = ST_READ;
        end else begin
            mode_now = ST_HOLD;
        end
    end

endmodule

// File: rtl/lane_sram_fsm.sv
module lane_sram_fsm
    import lane_sram_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sram_mode_e       mode_now,
    input  logic [LANES-1:0] lane_req,
    output logic [LANES-1:0] lane_oe,
    output logic [LANES-1:0] lane_wstb,
    output logic             rd_en
);

    sram_mode_e       state;
    logic [LANES-1:0] sel_q;

    // State register: records the mode decoded at each edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel_q <= '0;
        end else begin
            state <= mode_now;
            sel_q <= lane_req;
        end
    end

    // Outputs: strobes follow the live decode, drive needs a read at the last edge too
    always_comb begin
        lane_oe   = '0;
        lane_wstb = '0;
        rd_en     = 1'b0;
        unique case (mode_now)
            ST_IDLE: begin
            end
            ST_HOLD: begin
            end
            ST_READ: begin
                rd_en = 1'b1;
                if (state == ST_READ) begin
                    lane_oe = sel_q & lane_req;
                end
            end
            ST_WRITE: begin
                lane_wstb = lane_req;
            end
        endcase
    end

endmodule

// File: rtl/lane_sram_array.sv
module lane_sram_array
    import lane_sram_pkg::*;
#(
    parameter int unsigned LANES    = 2,
    parameter int unsigned STORE_AW = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [STORE_AW-1:0]       waddr,
    input  logic [LANES*BYTE_W-1:0]   wdata,
    input  logic [LANES-1:0]          wstb,
    input  logic                      rd_en,
    output logic [LANES*BYTE_W-1:0]   rd_q
);

    localparam int unsigned DEPTH = 1 << STORE_AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] bank [DEPTH];
        logic [BYTE_W-1:0] q_lane;

        always_ff @(posedge clk) begin
            if (wstb[g]) begin
                bank[waddr] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_lane <= '0;
            end else if (rd_en) begin
                q_lane <= bank[waddr];
            end
        end

        assign rd_q[g*BYTE_W +: BYTE_W] = q_lane;
    end

endmodule

// File: rtl/lane_sram_ctl.sv
module lane_sram_ctl
    import lane_sram_pkg::*;
#(
    parameter int unsigned ADDR_W   = 18,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned STORE_AW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 cs_hi,
    input  logic                 we_n,
    input  logic                 oe_n,
    input  logic [DATA_W/8-1:0]  byte_sel_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    din,
    output logic [DATA_W-1:0]    dout,
    output logic [DATA_W/8-1:0]  lane_oe,
    output logic [DATA_W/8-1:0]  lane_wstb
);

    localparam int unsigned LANES = DATA_W / BYTE_W;

    sram_mode_e        mode_now;
    logic [LANES-1:0]  lane_req;
    logic              rd_en;
    logic [DATA_W-1:0] rd_q;
    logic              unused_hi_addr;

    assign unused_hi_addr = ^addr[ADDR_W-1:STORE_AW];

    lane_sram_decode #(.LANES(LANES)) u_decode (
        .cs_n       (cs_n),
        .cs_hi      (cs_hi),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .byte_sel_n (byte_sel_n),
        .mode_now   (mode_now),
        .lane_req   (lane_req)
    );

    lane_sram_fsm #(.LANES(LANES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_now  (mode_now),
        .lane_req  (lane_req),
        .lane_oe   (lane_oe),
        .lane_wstb (lane_wstb),
        .rd_en     (rd_en)
    );

    lane_sram_array #(.LANES(LANES), .STORE_AW(STORE_AW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .waddr (addr[STORE_AW-1:0]),
        .wdata (din),
        .wstb  (lane_wstb),
        .rd_en (rd_en),
        .rd_q  (rd_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_dout
        assign dout[g*BYTE_W +: BYTE_W] = lane_oe[g] ? rd_q[g*BYTE_W +: BYTE_W] : '0;
    end

endmodule

// File: rtl/lane_sram_ctl_chk.sv
module lane_sram_ctl_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                cs_hi,
    input logic                we_n,
    input logic                oe_n,
    input logic [DATA_W/8-1:0] byte_sel_n,
    input logic [DATA_W-1:0]   dout,
    input logic [DATA_W/8-1:0] lane_oe,
    input logic [DATA_W/8-1:0] lane_wstb
);

    localparam int unsigned LANES = DATA_W / 8;

    logic rd_in;
    logic all_sel;
    assign rd_in   = !cs_n && cs_hi && we_n && !oe_n;
    assign all_sel = (byte_sel_n == '0);

    // R1
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !cs_hi || (&byte_sel_n)) |-> (lane_oe == '0 && lane_wstb == '0));

    // R7
    outdis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && cs_hi && we_n && oe_n) |-> (lane_oe == '0 && lane_wstb == '0));

    // R4
    read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_in |-> (lane_oe == '0));

    // R3
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_in && all_sel) && rd_in && all_sel) |-> (&lane_oe));

    // R5
    wstb_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_wstb) |-> (!cs_n && cs_hi && !we_n && ((lane_wstb & byte_sel_n) == '0)));

    // R8
    oe_wstb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|lane_oe) && (|lane_wstb)));

    for (genvar g = 0; g < LANES; g++) begin : g_zero
        // R10
        dout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_oe[g] |-> (dout[g*8 +: 8] == 8'h00));
    end

endmodule

bind lane_sram_ctl lane_sram_ctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .cs_hi      (cs_hi),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .byte_sel_n (byte_sel_n),
    .dout       (dout),
    .lane_oe    (lane_oe),
    .lane_wstb  (lane_wstb)
);

// File: tb/lane_sram_ctl_tb.sv
module lane_sram_ctl_tb;

    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        cs_hi = 1'b0;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [1:0]  byte_sel_n = 2'b11;
    logic [17:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic [1:0]  lane_oe;
    logic [1:0]  lane_wstb;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [15:0] m_mem [DEPTH];
    logic [15:0] m_q = '0;
    bit          m_prev_rd = 1'b0;
    logic [1:0]  m_prev_seln = 2'b11;

    always #2 clk = ~clk;

    lane_sram_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_hi(cs_hi), .we_n(we_n),
        .oe_n(oe_n), .byte_sel_n(byte_sel_n), .addr(addr), .din(din),
        .dout(dout), .lane_oe(lane_oe), .lane_wstb(lane_wstb)
    );

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: drive after falling edge, compare, advance model at rising edge
    task automatic step(bit csn, bit cshi, bit wen, bit oen, logic [1:0] bsel,
                        logic [17:0] a, logic [15:0] d, string tag);
        bit rd_now;
        bit wr_now;
        bit on;
        logic [1:0] e_oe;
        logic [1:0] e_wstb;
        logic [15:0] e_dout;
        int idx;
        cs_n = csn; cs_hi = cshi; we_n = wen; oe_n = oen;
        byte_sel_n = bsel; addr = a; din = d;
        #1;
        on     = !csn && cshi && (bsel != 2'b11);
        wr_now = on && !wen;
        rd_now = on && wen && !oen;
        e_wstb = wr_now ? ~bsel : 2'b00;
        for (int i = 0; i < 2; i++) begin
            e_oe[i] = m_prev_rd && rd_now && !m_prev_seln[i] && !bsel[i];
        end
        e_dout = {e_oe[1] ? m_q[15:8] : 8'h00, e_oe[0] ? m_q[7:0] : 8'h00};
        check(tag, "lane_oe", {14'd0, lane_oe}, {14'd0, e_oe});
        check(tag, "lane_wstb", {14'd0, lane_wstb}, {14'd0, e_wstb});
        check(tag, "dout", dout, e_dout);
        @(posedge clk);
        idx = int'(a) % DEPTH;
        if (rd_now) m_q = m_mem[idx];
        if (wr_now && !bsel[0]) m_mem[idx][7:0]  = d[7:0];
        if (wr_now && !bsel[1]) m_mem[idx][15:8] = d[15:8];
        m_prev_rd   = rd_now;
        m_prev_seln = on ? bsel : 2'b11;
        @(negedge clk);
    endtask

    task automatic idle(string tag);
        step(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 18'd0, 16'd0, tag);
    endtask

    task automatic wr(logic [1:0] bsel, logic [17:0] a, logic [15:0] d, bit oen, string tag);
        step(1'b0, 1'b1, 1'b0, oen, bsel, a, d, tag);
    endtask

    task automatic rd2(logic [1:0] bsel, logic [17:0] a, string tag);
        step(1'b0, 1'b1, 1'b1, 1'b0, bsel, a, 16'hdead, tag);
        step(1'b0, 1'b1, 1'b1, 1'b0, bsel, a, 16'hdead, tag);
        idle(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R2: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (lane_oe !== 2'b00 || dout !== 16'h0000) begin
            errors++;
            $display("FAIL R2 in reset actual=%b/%h expected=00/0000", lane_oe, dout);
        end
        rst_n = 1'b1;
        idle("R2");

        // R5: fill every word, output enable alternately active (ignored)
        for (int i = 0; i < DEPTH; i++) begin
            wr(2'b00, 18'(i), 16'(i * 16'h9e37 + 16'h1234), i[0], "R5");
        end
        idle("R5");

        // R3/R10/R1: read back under each byte-select combination
        for (int s = 0; s < 4; s++) begin
            rd2(2'(s), 18'd17, "R3");
            rd2(2'(s), 18'd900, "R10");
        end

        // R6: single-byte writes keep the other byte
        wr(2'b10, 18'd40, 16'hAB11, 1'b1, "R6");
        rd2(2'b00, 18'd40, "R6");
        wr(2'b01, 18'd41, 16'h22CD, 1'b0, "R6");
        rd2(2'b00, 18'd41, "R6");

        // R1: writes attempted in each standby form leave storage untouched
        step(1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 18'd50, 16'h5555, "R1");
        step(1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 18'd50, 16'h6666, "R1");
        step(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 18'd50, 16'h7777, "R1");
        rd2(2'b00, 18'd50, "R1");

        // R7: output disable
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd60, 16'h0, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 18'd60, 16'h0, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 18'd60, 16'h0, "R7");

        // R4: drive drops with output enable, then with one lane select
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd70, 16'h0, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd70, 16'h0, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 18'd70, 16'h0, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd71, 16'h0, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd71, 16'h0, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 18'd71, 16'h0, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd71, 16'h0, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd71, 16'h0, "R4");
        idle("R4");

        // R9: upper address bits alias onto the stored word
        wr(2'b00, 18'h3_0005, 16'hA5C3, 1'b1, "R9");
        rd2(2'b00, 18'd5, "R9");
        rd2(2'b00, 18'h1_4005, "R9");

        // R8 and general: mixed traffic, write and read back to back
        for (int n = 0; n < 400; n++) begin
            step(1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 5) != 0),
                 1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 3) == 0),
                 2'($urandom_range(0, 3)), 18'($urandom_range(0, 15) | ($urandom_range(0, 3) << 16)),
                 16'($urandom), "R8");
        end
        idle("R8");

        finish_run();
    end

endmodule